// File: doc/BRIEF.md
# ULPI PHY Pin Guard

This block sits on the PHY side of a ULPI link and decides, every clock, which ULPI pins the PHY may drive and which weak pull resistors are switched in. It holds DIR high while the link's active-low reset is asserted, so the link cannot start a transfer, and lets DIR fall a fixed number of edges after that reset is released. The release input passes through a two-flop synchronizer first. When the active-low chip select is high, the DATA, DIR and NXT output drivers are all turned off and STP is ignored, so the link may reuse those wires for other purposes.

A weak pull-up on STP is on by default. If STP goes high while no transmit is in progress, the link is taken to be absent or still powering up, and weak pull-downs are switched onto DATA until STP falls again. A disable bit from the register file turns both the pull-up and the protection off.

The block also drives the PLL power enable. Before the first release of reset, the enable simply follows chip select. After that release it becomes sticky, and only a power-on reset clears it. A registered reset strobe goes to the ULPI register file, which is outside this block, as are the transmit, receive and analog logic.

Top module: `ulpi_pin_guard`

## Requirements
- R1: While `por` is high, each edge loads dir=1, dir_oe=0, data_oe=0, nxt_oe=0, nxt_en=0, data_pd_en=0, stp_pu_en=1, pll_en=0 and reg_rst=1.
- R2: An edge that samples rst_n=0 sets dir=1, nxt_en=0 and reg_rst=1 at that edge.
- R3: Call the first edge that samples rst_n=1 after reset edge 1. reg_rst falls at edge 3. dir falls at edge 4 (with no phy_dir_req), and nxt_en rises at edge 4. Against an asynchronous release this gives four or five clock periods.
- R4: An edge that samples cs_n=1 clears dir_oe, nxt_oe and data_oe. An edge that samples cs_n=0 sets dir_oe=1 and nxt_oe=1.
- R5: The dir output is high when the reset hold is active or phy_dir_req is sampled high. data_oe is 1 exactly when dir is 1 and cs_n was sampled 0 at the same edge.
- R6: An edge that samples stp=1, tx_busy=0, cs_n=0 and prot_dis=0 sets data_pd_en=1.
- R7: Once data_pd_en is set, it stays set while stp stays 1, even if tx_busy rises. It clears at the first edge that samples stp=0.
- R8: stp=1 has no effect on data_pd_en when it is sampled with cs_n=1, or with tx_busy=1 while data_pd_en is 0.
- R9: An edge that samples prot_dis=1 clears both data_pd_en and stp_pu_en. With prot_dis=0, stp_pu_en is 1.
- R10: Until the first edge at which the synchronized reset is seen released, pll_en is loaded with the inverse of cs_n at each edge.
- R11: After that first release, pll_en is set by any edge that samples cs_n=0. It then stays 1, through later rst_n assertions, until `por`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ULPI clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst_n | input | 1 | Link reset pin, active low, asynchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| stp | input | 1 | STP pin level |
| tx_busy | input | 1 | High while a link transmit is in progress |
| prot_dis | input | 1 | Register bit: 1 disables STP pull-up and DATA protection |
| phy_dir_req | input | 1 | DIR request from the PHY's receive logic |
| dir | output | 1 | DIR level |
| dir_oe | output | 1 | DIR output driver enable |
| data_oe | output | 1 | DATA[7:0] output driver enable |
| nxt_oe | output | 1 | NXT output driver enable |
| nxt_en | output | 1 | 0 forces NXT low (reset hold) |
| data_pd_en | output | 1 | Weak pull-downs on DATA[7:0] |
| stp_pu_en | output | 1 | Weak pull-up on STP |
| pll_en | output | 1 | PLL power enable |
| reg_rst | output | 1 | Reset strobe to the ULPI register file |

## Verification
Every output is a register. Chip-select gating, the DIR request, protection set and clear, and the pre-decision PLL enable all appear at the first edge after the inputs change. The bench therefore drives on a falling edge and compares one falling edge later. The reset release is the one multi-edge path. The bench raises rst_n on a falling edge and samples after each of the next four rising edges, expecting reg_rst low from the third and DIR low only from the fourth. Reset entry is checked one edge after rst_n falls, ahead of the synchronizer.

// File: rtl/ulpi_guard_pkg.sv
package ulpi_guard_pkg;
  localparam int unsigned SYNC_STAGES_DEF   = 2;
  localparam int unsigned RELEASE_EDGES_DEF = 4;

  typedef struct packed {
    logic data;
    logic dir;
    logic nxt;
  } pin_oe_t;
endpackage

// File: rtl/ulpi_guard_release.sv
module ulpi_guard_release #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned RELEASE_EDGES = 4
) (
  input  logic clk,
  input  logic por,
  input  logic rst_n,
  output logic synced,
  output logic hold_req,
  output logic core_rst
);
  localparam int unsigned CNT_TGT = RELEASE_EDGES - SYNC_STAGES - 1;
  localparam int unsigned CNT_W   = $clog2(CNT_TGT + 2);
  localparam logic [CNT_W-1:0] TGT_V = CNT_W'(CNT_TGT);

  logic [SYNC_STAGES-1:0] chain;
  logic [CNT_W-1:0]       cnt;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (por) chain[0] <= 1'b0;
          else     chain[0] <= rst_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (por) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign synced = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (por || !synced) cnt <= '0;
    else if (cnt < TGT_V) cnt <= cnt + 1'b1;
  end

  assign core_rst = !rst_n || !synced;
  assign hold_req = core_rst || (cnt < TGT_V);
endmodule

// File: rtl/ulpi_guard_protect.sv
module ulpi_guard_protect (
  input  logic clk,
  input  logic por,
  input  logic cs_n,
  input  logic stp,
  input  logic tx_busy,
  input  logic prot_dis,
  output logic pd_en,
  output logic pu_en
);
  logic armed;
  logic set_cond;

  assign armed    = !prot_dis && !cs_n;
  assign set_cond = stp && !tx_busy;

  always_ff @(posedge clk) begin
    if (por) begin
      pd_en <= 1'b0;
      pu_en <= 1'b1;
    end else begin
      pd_en <= armed && (set_cond || (pd_en && stp));
      pu_en <= !prot_dis;
    end
  end
endmodule

// File: rtl/ulpi_guard_pll.sv
module ulpi_guard_pll (
  input  logic clk,
  input  logic por,
  input  logic cs_n,
  input  logic synced,
  output logic pll_en
);
  logic decided;

  always_ff @(posedge clk) begin
    if (por) begin
      decided <= 1'b0;
      pll_en  <= 1'b0;
    end else begin
      if (synced) decided <= 1'b1;
      if (decided) pll_en <= pll_en || !cs_n;
      else         pll_en <= !cs_n;
    end
  end
endmodule

// File: rtl/ulpi_pin_guard.sv
module ulpi_pin_guard
  import ulpi_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = SYNC_STAGES_DEF,
  parameter int unsigned RELEASE_EDGES = RELEASE_EDGES_DEF
) (
  input  logic clk,
  input  logic por,
  input  logic rst_n,
  input  logic cs_n,
  input  logic stp,
  input  logic tx_busy,
  input  logic prot_dis,
  input  logic phy_dir_req,
  output logic dir,
  output logic dir_oe,
  output logic data_oe,
  output logic nxt_oe,
  output logic nxt_en,
  output logic data_pd_en,
  output logic stp_pu_en,
  output logic pll_en,
  output logic reg_rst
);
  logic    synced;
  logic    hold_req;
  logic    core_rst;
  logic    dir_next;
  pin_oe_t oe_q;
  logic    dir_q;
  logic    nxt_en_q;
  logic    reg_rst_q;

  ulpi_guard_release #(
    .SYNC_STAGES  (SYNC_STAGES),
    .RELEASE_EDGES(RELEASE_EDGES)
  ) u_release (
    .clk     (clk),
    .por     (por),
    .rst_n   (rst_n),
    .synced  (synced),
    .hold_req(hold_req),
    .core_rst(core_rst)
  );

  ulpi_guard_protect u_protect (
    .clk     (clk),
    .por     (por),
    .cs_n    (cs_n),
    .stp     (stp),
    .tx_busy (tx_busy),
    .prot_dis(prot_dis),
    .pd_en   (data_pd_en),
    .pu_en   (stp_pu_en)
  );

  ulpi_guard_pll u_pll (
    .clk   (clk),
    .por   (por),
    .cs_n  (cs_n),
    .synced(synced),
    .pll_en(pll_en)
  );

  assign dir_next = hold_req || phy_dir_req;

  always_ff @(posedge clk) begin
    if (por) begin
      dir_q     <= 1'b1;
      oe_q      <= '0;
      nxt_en_q  <= 1'b0;
      reg_rst_q <= 1'b1;
    end else begin
      dir_q     <= dir_next;
      oe_q.dir  <= !cs_n;
      oe_q.nxt  <= !cs_n;
      oe_q.data <= !cs_n && dir_next;
      nxt_en_q  <= !hold_req;
      reg_rst_q <= core_rst;
    end
  end

  assign dir     = dir_q;
  assign dir_oe  = oe_q.dir;
  assign nxt_oe  = oe_q.nxt;
  assign data_oe = oe_q.data;
  assign nxt_en  = nxt_en_q;
  assign reg_rst = reg_rst_q;
endmodule

// File: rtl/ulpi_pin_guard_chk.sv
module ulpi_pin_guard_chk (
  input logic clk,
  input logic por,
  input logic rst_n,
  input logic cs_n,
  input logic stp,
  input logic prot_dis,
  input logic dir,
  input logic dir_oe,
  input logic data_oe,
  input logic nxt_oe,
  input logic nxt_en,
  input logic data_pd_en,
  input logic stp_pu_en,
  input logic pll_en,
  input logic reg_rst
);
  assert_reset_hold_R2: assert property (@(posedge clk) disable iff (por)
    !rst_n |=> (dir && !nxt_en && reg_rst));

  assert_deselect_tristate_R4: assert property (@(posedge clk) disable iff (por)
    cs_n |=> (!dir_oe && !nxt_oe && !data_oe));

  assert_data_follows_dir_R5: assert property (@(posedge clk) disable iff (por)
    data_oe |-> dir);

  assert_protect_clear_R7: assert property (@(posedge clk) disable iff (por)
    !stp |=> !data_pd_en);

  assert_disable_bit_R9: assert property (@(posedge clk) disable iff (por)
    prot_dis |=> (!data_pd_en && !stp_pu_en));

  assert_pll_sticky_R11: assert property (@(posedge clk) disable iff (por)
    (pll_en && !reg_rst) |=> pll_en);
endmodule

bind ulpi_pin_guard ulpi_pin_guard_chk u_chk (
  .clk       (clk),
  .por       (por),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .stp       (stp),
  .prot_dis  (prot_dis),
  .dir       (dir),
  .dir_oe    (dir_oe),
  .data_oe   (data_oe),
  .nxt_oe    (nxt_oe),
  .nxt_en    (nxt_en),
  .data_pd_en(data_pd_en),
  .stp_pu_en (stp_pu_en),
  .pll_en    (pll_en),
  .reg_rst   (reg_rst)
);

// File: tb/ulpi_pin_guard_test.sv
module ulpi_pin_guard_test;
  logic clk = 1'b0;
  logic por = 1'b1;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic stp = 1'b0;
  logic tx_busy = 1'b0;
  logic prot_dis = 1'b0;
  logic phy_dir_req = 1'b0;
  logic dir, dir_oe, data_oe, nxt_oe, nxt_en, data_pd_en, stp_pu_en, pll_en, reg_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ulpi_pin_guard uut (
    .clk(clk), .por(por), .rst_n(rst_n), .cs_n(cs_n), .stp(stp),
    .tx_busy(tx_busy), .prot_dis(prot_dis), .phy_dir_req(phy_dir_req),
    .dir(dir), .dir_oe(dir_oe), .data_oe(data_oe), .nxt_oe(nxt_oe),
    .nxt_en(nxt_en), .data_pd_en(data_pd_en), .stp_pu_en(stp_pu_en),
    .pll_en(pll_en), .reg_rst(reg_rst)
  );

  // inputs {cs_n, stp, tx_busy, prot_dis, phy_dir_req}
  // expected {dir_oe, data_oe, dir, data_pd_en, stp_pu_en}
  localparam int NVEC = 9;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b00000_10001,  // idle, released (R4 R5 R9)
    10'b00001_11101,  // dir request drives data (R5)
    10'b01000_10011,  // stp high, no transmit: protect (R6)
    10'b01100_10011,  // stp stays high, tx starts: hold (R7)
    10'b00100_10001,  // stp low: clear (R7)
    10'b01100_10001,  // stp high during transmit: no effect (R8)
    10'b01010_10000,  // disable bit (R9)
    10'b11001_00101,  // deselected, stp ignored (R4 R8)
    10'b00000_10001   // back to idle
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: state under power-on reset
    check("R1 outputs", {dir, dir_oe, data_oe, nxt_oe, nxt_en, data_pd_en, stp_pu_en, pll_en},
          8'b1000_0010);
    check("R1 reg_rst", {7'd0, reg_rst}, 8'd1);
    por = 1'b0;
    step(2);
    // R10: before release pll follows chip select; R5 data driven with dir
    check("R10 pll before release", {7'd0, pll_en}, 8'd1);
    check("R5 data_oe during hold", {6'd0, dir, data_oe}, 8'b11);
    check("R2 nxt low in reset", {7'd0, nxt_en}, 8'd0);
    rst_n = 1'b1;
    step(2);
    check("R3 dir after 2 edges", {6'd0, dir, reg_rst}, 8'b11);
    step(1);
    check("R3 edge 3", {5'd0, dir, reg_rst, nxt_en}, 8'b100);
    step(1);
    check("R3 edge 4", {5'd0, dir, data_oe, nxt_en}, 8'b001);
    cs_n = 1'b1;
    step(1);
    check("R11 pll sticky after release", {7'd0, pll_en}, 8'd1);
    cs_n = 1'b0;
    step(1);

    for (int i = 0; i < NVEC; i++) begin
      {cs_n, stp, tx_busy, prot_dis, phy_dir_req} = VEC[i][9:5];
      step(1);
      check($sformatf("R4 R5 R6 R7 R8 R9 vector %0d", i),
            {3'd0, dir_oe, data_oe, dir, data_pd_en, stp_pu_en}, {3'd0, VEC[i][4:0]});
    end

    // R2: reset re-entry acts at the next edge
    rst_n = 1'b0;
    step(1);
    check("R2 re-entry", {5'd0, dir, nxt_en, reg_rst}, 8'b101);
    // R4: deselect during reset
    cs_n = 1'b1;
    step(1);
    check("R4 deselect in reset", {5'd0, dir_oe, nxt_oe, data_oe}, 8'd0);
    check("R11 pll kept through reset", {7'd0, pll_en}, 8'd1);
    cs_n = 1'b0;
    step(1);
    check("R4 reselect", {6'd0, dir_oe, nxt_oe}, 8'b11);

    // Power-up with chip select high
    cs_n = 1'b1;
    por = 1'b1;
    step(2);
    por = 1'b0;
    step(1);
    check("R10 pll off when deselected", {7'd0, pll_en}, 8'd0);
    cs_n = 1'b0;
    step(1);
    check("R10 pll follows select", {7'd0, pll_en}, 8'd1);
    cs_n = 1'b1;
    step(1);
    check("R10 pll follows deselect", {7'd0, pll_en}, 8'd0);
    rst_n = 1'b1;
    step(5);
    check("R11 decided while deselected", {7'd0, pll_en}, 8'd0);
    cs_n = 1'b0;
    step(1);
    cs_n = 1'b1;
    step(2);
    check("R11 pll latched on", {7'd0, pll_en}, 8'd1);

    // R7: protect cleared by disable while held
    cs_n = 1'b0;
    stp = 1'b1;
    step(1);
    check("R6 protect set", {7'd0, data_pd_en}, 8'd1);
    prot_dis = 1'b1;
    step(1);
    check("R9 disable clears", {6'd0, data_pd_en, stp_pu_en}, 8'd0);
    prot_dis = 1'b0;
    stp = 1'b0;
    step(1);
    check("R9 pull-up restored", {6'd0, data_pd_en, stp_pu_en}, 8'b01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule